// File: doc/BRIEF.md
# Configurable Routing Switch Matrix

This block is a digital model of a programmable interconnect switch box. A bank of input wire segments enters the block. Every output wire segment is driven by a buffered, one-way selection point, and a configuration word chooses which input reaches it. Four kinds of point are built side by side. A decoded multiplexer uses a binary select field plus an enable. A one-hot multiplexer uses one bit per candidate input. A compound cross-point joins four segment ends through six pairwise links. A single-bit break-point either passes a segment or isolates it.

The configuration word is loaded one bit per clock through a serial port while a load strobe is high. While the strobe is high, every output and the error flag are held low. Once the strobe drops, the word that was shifted in stays in place and sets the routing. The outputs then follow the input segments combinationally. The block models connection and isolation as enable-gated logic. It does not model bidirectional nets or analog switch behaviour.

Top module: `rsm_switch_matrix`

## Requirements
- R1: An active-low `rst_n` clears the whole configuration word, so every output and `cfg_err` read 0 until new configuration is loaded.
- R2: On each clock with `cfg_load` high, the word shifts one place toward bit 0 and `cfg_din` enters at bit CFG_W-1 (38 bits by default). The first bit sent therefore ends up at bit 0 after CFG_W shifts, and any extra bits push the oldest ones out.
- R3: While `cfg_load` is high, `out_seg` is all zero and `cfg_err` is 0, whatever the inputs and the stored word.
- R4: Decoded point d drives `out_seg[d]`. Its field starts at bit d*(SEL_W+1): the low SEL_W bits give a binary index and the next bit is an enable. When enabled, the output equals `in_seg[index]`; when disabled, it is 0.
- R5: One-hot point o drives `out_seg[N_DEC+o]` from the IN_W-bit field starting at N_DEC*(SEL_W+1)+o*IN_W. Bit j of that field selects `in_seg[j]`, and an all-zero field drives 0.
- R6: If any one-hot field has more than one bit set, `cfg_err` is high and that point passes the lowest-indexed selected input. When every one-hot field has at most one bit set, `cfg_err` is 0.
- R7: Cross-point x joins ends e=0..3, which read `in_seg[4x+e]` and drive `out_seg[N_DEC+N_ONE+4x+e]`. Its 6-bit field at offset N_DEC*(SEL_W+1)+N_ONE*IN_W+6x enables, from bit 0 upward, the links 0-1, 0-2, 0-3, 1-2, 1-3 and 2-3. Each output end is the OR of the inputs of the ends linked to it.
- R8: Two disjoint link pairs in one cross-point carry two separate signals with no crosstalk (for example, links 0-1 and 2-3 give out0=in1, out1=in0, out2=in3, out3=in2).
- R9: Break-point b drives the last outputs, `out_seg[N_DEC+N_ONE+4*N_XPT+b]`, equal to `in_seg[b]` ANDed with configuration bit CFG_W-N_BRK+b.
- R10: While `cfg_load` is low, `cfg_din` has no effect, and the stored word and routing stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration shift register |
| rst_n | input | 1 | Asynchronous active-low reset of the configuration |
| cfg_load | input | 1 | Shift enable; holds outputs low while high |
| cfg_din | input | 1 | Serial configuration bit |
| in_seg | input | IN_W (8) | Input wire segments |
| out_seg | output | OUT_W (14) | Output wire segments: decoded, one-hot, cross-point ends, break-points |
| cfg_err | output | 1 | A one-hot field has more than one bit set |

## Verification
A corrupt bit in the configuration register is not visible on its own: it shows up only on the output that its field controls, and only when the input it wrongly selects differs from the correct one. For that reason the inputs are changed every cycle, and each output is compared on every clock against a model of the shifted word. A fault in shift order or length shows as routing to the wrong segment in the first cycle after the strobe drops. A fault in link wiring or the priority rule shows in the first cycle in which the two competing inputs differ.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
   localparam int XPT_ENDS  = 4;
   localparam int XPT_LINKS = 6;

   // link p joins end pair_a(p) with end pair_b(p); link bit order is fixed
   function automatic logic [1:0] pair_a(input logic [2:0] p);
      case (p)
         3'd0, 3'd1, 3'd2: pair_a = 2'd0;
         3'd3, 3'd4:       pair_a = 2'd1;
         default:          pair_a = 2'd2;
      endcase
   endfunction

   function automatic logic [1:0] pair_b(input logic [2:0] p);
      case (p)
         3'd0:       pair_b = 2'd1;
         3'd1, 3'd3: pair_b = 2'd2;
         default:    pair_b = 2'd3;
      endcase
   endfunction
endpackage

// File: rtl/rsm_cfg_chain.sv
module rsm_cfg_chain #(
   parameter int CFG_W = 38
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             din,
   output logic [CFG_W-1:0] cfg_q
);
   if (CFG_W < 2) begin : g_bad_w
      $error("rsm_cfg_chain: CFG_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= '0;
      else if (load)
         cfg_q <= {din, cfg_q[CFG_W-1:1]};
   end
endmodule

// File: rtl/rsm_dec_point.sv
module rsm_dec_point #(
   parameter  int SEL_W = 3,
   localparam int IN_W  = 1 << SEL_W
) (
   input  logic [IN_W-1:0]  seg_in,
   input  logic [SEL_W-1:0] sel,
   input  logic             en,
   output logic             seg_out
);
   assign seg_out = en & seg_in[sel];
endmodule

// File: rtl/rsm_onehot_point.sv
module rsm_onehot_point #(
   parameter int IN_W = 8
) (
   input  logic [IN_W-1:0] seg_in,
   input  logic [IN_W-1:0] mask,
   output logic            seg_out,
   output logic            multi
);
   logic taken;

   always_comb begin
      seg_out = 1'b0;
      taken   = 1'b0;
      for (int j = 0; j < IN_W; j++) begin
         if (mask[j] && !taken) begin
            seg_out = seg_in[j];
            taken   = 1'b1;
         end
      end
   end

   assign multi = ($countones(mask) > 1);
endmodule

// File: rtl/rsm_xpoint.sv
module rsm_xpoint
   import rsm_pkg::*;
(
   input  logic [XPT_ENDS-1:0]  ends_in,
   input  logic [XPT_LINKS-1:0] link,
   output logic [XPT_ENDS-1:0]  ends_out
);
   always_comb begin
      ends_out = '0;
      for (int p = 0; p < XPT_LINKS; p++) begin
         if (link[p]) begin
            ends_out[pair_a(3'(p))] = ends_out[pair_a(3'(p))] | ends_in[pair_b(3'(p))];
            ends_out[pair_b(3'(p))] = ends_out[pair_b(3'(p))] | ends_in[pair_a(3'(p))];
         end
      end
   end
endmodule

// File: rtl/rsm_switch_matrix.sv
module rsm_switch_matrix
   import rsm_pkg::*;
#(
   parameter  int SEL_W   = 3,
   parameter  int N_DEC   = 2,
   parameter  int N_ONE   = 2,
   parameter  int N_XPT   = 2,
   parameter  int N_BRK   = 2,
   localparam int IN_W    = 1 << SEL_W,
   localparam int DEC_FW  = SEL_W + 1,
   localparam int CB_ONE  = N_DEC * DEC_FW,
   localparam int CB_XPT  = CB_ONE + N_ONE * IN_W,
   localparam int CB_BRK  = CB_XPT + XPT_LINKS * N_XPT,
   localparam int CFG_W   = CB_BRK + N_BRK,
   localparam int OFF_ONE = N_DEC,
   localparam int OFF_XPT = OFF_ONE + N_ONE,
   localparam int OFF_BRK = OFF_XPT + XPT_ENDS * N_XPT,
   localparam int OUT_W   = OFF_BRK + N_BRK
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_load,
   input  logic             cfg_din,
   input  logic [IN_W-1:0]  in_seg,
   output logic [OUT_W-1:0] out_seg,
   output logic             cfg_err
);
   if (SEL_W < 1 || SEL_W > 6) begin : g_bad_sel
      $error("rsm_switch_matrix: SEL_W out of range 1..6");
   end
   if (N_DEC < 1 || N_ONE < 1 || N_XPT < 1 || N_BRK < 1) begin : g_bad_cnt
      $error("rsm_switch_matrix: each point kind needs at least one instance");
   end
   if (XPT_ENDS * N_XPT > IN_W) begin : g_bad_xpt
      $error("rsm_switch_matrix: cross-point ends exceed input segments");
   end
   if (N_BRK > IN_W) begin : g_bad_brk
      $error("rsm_switch_matrix: more break-points than input segments");
   end

   logic [CFG_W-1:0] cfg_q;
   logic [OUT_W-1:0] raw_seg;
   logic [N_ONE-1:0] multi_v;

   rsm_cfg_chain #(.CFG_W(CFG_W)) u_chain (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cfg_load),
      .din   (cfg_din),
      .cfg_q (cfg_q)
   );

   for (genvar d = 0; d < N_DEC; d++) begin : g_dec
      rsm_dec_point #(.SEL_W(SEL_W)) u_pt (
         .seg_in  (in_seg),
         .sel     (cfg_q[d*DEC_FW +: SEL_W]),
         .en      (cfg_q[d*DEC_FW + SEL_W]),
         .seg_out (raw_seg[d])
      );
   end

   for (genvar o = 0; o < N_ONE; o++) begin : g_one
      rsm_onehot_point #(.IN_W(IN_W)) u_pt (
         .seg_in  (in_seg),
         .mask    (cfg_q[CB_ONE + o*IN_W +: IN_W]),
         .seg_out (raw_seg[OFF_ONE + o]),
         .multi   (multi_v[o])
      );
   end

   for (genvar x = 0; x < N_XPT; x++) begin : g_xpt
      rsm_xpoint u_pt (
         .ends_in  (in_seg[XPT_ENDS*x +: XPT_ENDS]),
         .link     (cfg_q[CB_XPT + XPT_LINKS*x +: XPT_LINKS]),
         .ends_out (raw_seg[OFF_XPT + XPT_ENDS*x +: XPT_ENDS])
      );
   end

   for (genvar b = 0; b < N_BRK; b++) begin : g_brk
      assign raw_seg[OFF_BRK + b] = cfg_q[CB_BRK + b] & in_seg[b];
   end

   assign out_seg = cfg_load ? '0 : raw_seg;
   assign cfg_err = !cfg_load && (|multi_v);
endmodule

// File: rtl/rsm_checker.sv
module rsm_checker
   import rsm_pkg::*;
#(
   parameter  int SEL_W   = 3,
   parameter  int N_DEC   = 2,
   parameter  int N_ONE   = 2,
   parameter  int N_XPT   = 2,
   parameter  int N_BRK   = 2,
   localparam int IN_W    = 1 << SEL_W,
   localparam int DEC_FW  = SEL_W + 1,
   localparam int CB_ONE  = N_DEC * DEC_FW,
   localparam int CB_XPT  = CB_ONE + N_ONE * IN_W,
   localparam int CB_BRK  = CB_XPT + XPT_LINKS * N_XPT,
   localparam int CFG_W   = CB_BRK + N_BRK,
   localparam int OFF_ONE = N_DEC,
   localparam int OFF_XPT = OFF_ONE + N_ONE,
   localparam int OFF_BRK = OFF_XPT + XPT_ENDS * N_XPT,
   localparam int OUT_W   = OFF_BRK + N_BRK
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_load,
   input logic             cfg_din,
   input logic [IN_W-1:0]  in_seg,
   input logic [OUT_W-1:0] out_seg,
   input logic             cfg_err,
   input logic [CFG_W-1:0] cfg_q
);
   logic any_multi;
   always_comb begin
      any_multi = 1'b0;
      for (int o = 0; o < N_ONE; o++)
         if ($countones(cfg_q[CB_ONE + o*IN_W +: IN_W]) > 1) any_multi = 1'b1;
   end

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (out_seg == '0 && !cfg_err)); // R1
   AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> cfg_q[CFG_W-1] == $past(cfg_din)); // R2
   AST_LOAD_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |-> (out_seg == '0 && !cfg_err)); // R3
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load |=> $stable(cfg_q)); // R10
   AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_load && any_multi) |-> cfg_err); // R6
   AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_load && !any_multi) |-> !cfg_err); // R6

   for (genvar d = 0; d < N_DEC; d++) begin : g_dec_chk
      AST_DEC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
         (!cfg_load && !cfg_q[d*DEC_FW + SEL_W]) |-> !out_seg[d]); // R4
      AST_DEC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         (!cfg_load && cfg_q[d*DEC_FW + SEL_W]) |->
            out_seg[d] == in_seg[cfg_q[d*DEC_FW +: SEL_W]]); // R4
   end

   for (genvar o = 0; o < N_ONE; o++) begin : g_one_chk
      AST_ONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
         (!cfg_load && cfg_q[CB_ONE + o*IN_W +: IN_W] == '0) |-> !out_seg[OFF_ONE + o]); // R5
      AST_ONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
         (!cfg_load && $onehot0(cfg_q[CB_ONE + o*IN_W +: IN_W]) &&
          (cfg_q[CB_ONE + o*IN_W +: IN_W] & in_seg) == '0) |-> !out_seg[OFF_ONE + o]); // R5
   end

   for (genvar x = 0; x < N_XPT; x++) begin : g_xpt_chk
      for (genvar p = 0; p < XPT_LINKS; p++) begin : g_link
         localparam int EA = int'(pair_a(3'(p)));
         localparam int EB = int'(pair_b(3'(p)));
         AST_XPT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_load && cfg_q[CB_XPT + XPT_LINKS*x + p] && in_seg[XPT_ENDS*x + EA])
               |-> out_seg[OFF_XPT + XPT_ENDS*x + EB]); // R7
         AST_XPT_REV: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_load && cfg_q[CB_XPT + XPT_LINKS*x + p] && in_seg[XPT_ENDS*x + EB])
               |-> out_seg[OFF_XPT + XPT_ENDS*x + EA]); // R7
      end
   end

   for (genvar b = 0; b < N_BRK; b++) begin : g_brk_chk
      AST_BRK_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
         (!cfg_load && !cfg_q[CB_BRK + b]) |-> !out_seg[OFF_BRK + b]); // R9
   end
endmodule

bind rsm_switch_matrix rsm_checker #(
   .SEL_W(SEL_W), .N_DEC(N_DEC), .N_ONE(N_ONE), .N_XPT(N_XPT), .N_BRK(N_BRK)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_load (cfg_load),
   .cfg_din  (cfg_din),
   .in_seg   (in_seg),
   .out_seg  (out_seg),
   .cfg_err  (cfg_err),
   .cfg_q    (cfg_q)
);

// File: tb/sim_rsm_switch_matrix.sv
`timescale 1ns/1ps
module sim_rsm_switch_matrix;
   localparam int SEL_W  = 3;
   localparam int N_DEC  = 2;
   localparam int N_ONE  = 2;
   localparam int N_XPT  = 2;
   localparam int N_BRK  = 2;
   localparam int IN_W   = 1 << SEL_W;
   localparam int DEC_FW = SEL_W + 1;
   localparam int CB_ONE = N_DEC * DEC_FW;
   localparam int CB_XPT = CB_ONE + N_ONE * IN_W;
   localparam int CB_BRK = CB_XPT + 6 * N_XPT;
   localparam int CFG_W  = CB_BRK + N_BRK;
   localparam int OUT_W  = N_DEC + N_ONE + 4 * N_XPT + N_BRK;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             cfg_load;
   logic             cfg_din;
   logic [IN_W-1:0]  in_seg;
   logic [OUT_W-1:0] out_seg;
   logic             cfg_err;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done  = 0;
   string tag   = "R1";
   bit    mq[$];

   always #2.5 clk = ~clk;

   rsm_switch_matrix #(.SEL_W(SEL_W), .N_DEC(N_DEC), .N_ONE(N_ONE),
                       .N_XPT(N_XPT), .N_BRK(N_BRK)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_din(cfg_din),
      .in_seg(in_seg), .out_seg(out_seg), .cfg_err(cfg_err));

   // reference: configuration as a bit queue, index 0 = oldest surviving bit
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mq.delete();
         for (int i = 0; i < CFG_W; i++) mq.push_back(1'b0);
      end else if (cfg_load) begin
         mq.push_back(cfg_din);
         void'(mq.pop_front());
      end
   end

   function automatic void model(output logic [OUT_W-1:0] o, output logic e);
      int la[6] = '{0, 0, 0, 1, 1, 2};
      int lb[6] = '{1, 2, 3, 2, 3, 3};
      o = '0;
      e = 1'b0;
      if (cfg_load || mq.size() != CFG_W) return;
      for (int d = 0; d < N_DEC; d++) begin
         int idx = 0;
         for (int k = 0; k < SEL_W; k++) if (mq[d*DEC_FW + k]) idx += (1 << k);
         o[d] = mq[d*DEC_FW + SEL_W] ? in_seg[idx] : 1'b0;
      end
      for (int p = 0; p < N_ONE; p++) begin
         int cnt = 0;
         int first = -1;
         for (int j = 0; j < IN_W; j++)
            if (mq[CB_ONE + p*IN_W + j]) begin
               cnt++;
               if (first < 0) first = j;
            end
         o[N_DEC + p] = (first >= 0) ? in_seg[first] : 1'b0;
         if (cnt > 1) e = 1'b1;
      end
      for (int x = 0; x < N_XPT; x++)
         for (int l = 0; l < 6; l++)
            if (mq[CB_XPT + 6*x + l]) begin
               if (in_seg[4*x + lb[l]]) o[N_DEC + N_ONE + 4*x + la[l]] = 1'b1;
               if (in_seg[4*x + la[l]]) o[N_DEC + N_ONE + 4*x + lb[l]] = 1'b1;
            end
      for (int b = 0; b < N_BRK; b++)
         o[N_DEC + N_ONE + 4*N_XPT + b] = mq[CB_BRK + b] & in_seg[b];
   endfunction

   task automatic check_now();
      logic [OUT_W-1:0] eo;
      logic ee;
      model(eo, ee);
      n_cmp++;
      if (out_seg !== eo || cfg_err !== ee) begin
         n_bad++;
         $display("FAIL %s: out_seg=%b cfg_err=%b expected out_seg=%b cfg_err=%b",
                  tag, out_seg, cfg_err, eo, ee);
      end
   endtask

   task automatic run(input int n);
      repeat (n) begin
         @(negedge clk);
         check_now();
         in_seg  = IN_W'($urandom);
         cfg_din = 1'($urandom);   // R10: ignored while cfg_load is low
      end
   endtask

   task automatic load_word(input logic [CFG_W-1:0] w, input int extra);
      string keep = tag;
      tag = "R3";
      for (int i = -extra; i < CFG_W; i++) begin
         @(negedge clk);
         check_now();
         cfg_load = 1'b1;
         cfg_din  = (i < 0) ? 1'($urandom) : w[i];
         in_seg   = IN_W'($urandom);
      end
      @(negedge clk);
      check_now();
      cfg_load = 1'b0;
      tag = keep;
   endtask

   function automatic logic [CFG_W-1:0] put_dec(input logic [CFG_W-1:0] w,
                                                input int d, input int sel, input bit en);
      for (int k = 0; k < SEL_W; k++) w[d*DEC_FW + k] = sel[k];
      w[d*DEC_FW + SEL_W] = en;
      return w;
   endfunction

   function automatic logic [CFG_W-1:0] put_one(input logic [CFG_W-1:0] w,
                                                input int p, input logic [IN_W-1:0] m);
      for (int j = 0; j < IN_W; j++) w[CB_ONE + p*IN_W + j] = m[j];
      return w;
   endfunction

   function automatic logic [CFG_W-1:0] put_xpt(input logic [CFG_W-1:0] w,
                                                input int x, input logic [5:0] l);
      for (int j = 0; j < 6; j++) w[CB_XPT + 6*x + j] = l[j];
      return w;
   endfunction

   initial begin
      logic [CFG_W-1:0] w;
      rst_n = 1'b0; cfg_load = 1'b0; cfg_din = 1'b0; in_seg = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      tag = "R1"; run(6);

      // R4: decoded point 0 enabled on index 5, point 1 disabled
      w = '0; w = put_dec(w, 0, 5, 1'b1); w = put_dec(w, 1, 2, 1'b0);
      load_word(w, 0); tag = "R4"; run(24);
      w = put_dec(w, 1, 7, 1'b1);
      load_word(w, 0); tag = "R4"; run(16);

      // R5: single selection and empty selection
      w = '0; w = put_one(w, 0, 8'b0100_0000); w = put_one(w, 1, 8'b0);
      load_word(w, 0); tag = "R5"; run(20);

      // R6: multi-hot field, lowest index (2) wins, error raised
      w = '0; w = put_one(w, 0, 8'b0010_1100); w = put_one(w, 1, 8'b1000_0000);
      load_word(w, 0); tag = "R6"; run(24);

      // R7: single link and a three-end chain
      w = '0; w = put_xpt(w, 0, 6'b000010); w = put_xpt(w, 1, 6'b001001);
      load_word(w, 0); tag = "R7"; run(24);

      // R8: two disjoint pairs in each cross-point
      w = '0; w = put_xpt(w, 0, 6'b100001); w = put_xpt(w, 1, 6'b010010);
      load_word(w, 0); tag = "R8"; run(24);

      // R9: break-point 0 closed, 1 open
      w = '0; w[CB_BRK] = 1'b1;
      load_word(w, 0); tag = "R9"; run(20);

      // R10: long idle stretch with cfg_din toggling
      tag = "R10"; run(40);

      // R2: over-long stream, oldest bits dropped
      w = '0; w = put_dec(w, 0, 3, 1'b1); w = put_one(w, 1, 8'b0000_0010);
      w = put_xpt(w, 1, 6'b100100); w[CB_BRK + 1] = 1'b1;
      load_word(w, 9); tag = "R2"; run(30);

      // R1: reset in mid-run clears the routing
      @(negedge clk); rst_n = 1'b0;
      tag = "R1"; run(3);
      @(negedge clk); rst_n = 1'b1;
      run(10);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL %s: watchdog expired, actual=running expected=finished", tag);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule